// File: doc/BRIEF.md
# Split Metadata/Data Way Victim Selector

This block selects the victim way for one cache set whose metadata array has more ways than its data array. The low metadata ways each own a fixed data way. The upper metadata ways have no data storage and can only hold lines whose data currently lives elsewhere. Recency is tracked by two separate tree pseudo-LRU structures, one over the paired ways and one over the metadata-only ways. Each tree is padded to the next power of two, and its padding leaves are never chosen.

For each fill request the selector takes the request kind, the valid and delegated bits of every way, and an optional hit update, and it returns the victim way and an action code in the same cycle. An ordinary fill needs data, so it is confined to the paired ways. A metadata-only fill may go to either group. The group is chosen by a cheap weighted pseudo-random draw taken from a free-running cycle counter. A line coming back from delegation must land in a paired way. If the paired victim is itself a metadata-only resident, the two lines trade places instead of one being evicted. The tree of the chosen way is updated at the clock edge that ends a valid request.

Top module: `meta_way_victim`

## Requirements
- R1: A request of kind 0 (ordinary fill) always selects a way in the paired group, ways 0 to 14.
- R2: A 5-bit counter is cleared by reset and increments on every clock edge. For a request of kind 1 (metadata-only fill), the victim comes from the paired group when the counter value modulo 20 is below 15, and from ways 15 to 19 otherwise.
- R3: A request of kind 2 (return from delegation) selects a paired way. With no free paired way, the action is 2 (swap) when that way's delegated bit is set, and 1 (evict) when it is clear.
- R4: If the chosen group has an invalid way, the lowest-indexed invalid way in that group is the victim and the action is 0 (place), regardless of recency state.
- R5: Both trees start from reset with all node bits zero. A fully valid paired group then yields victims 0, 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7 for successive ordinary fills. The metadata-only group yields way 15 first, then way 19.
- R6: A padding leaf is never selected. The sixteenth successive ordinary fill over a fully valid paired group yields way 14.
- R7: A hit updates only the tree that owns the hit way. A hit on way 15 right after reset makes way 19 the metadata-only victim, while the paired victim stays way 0.
- R8: When a hit and a valid fill update the same tree in the same cycle, the fill's update takes precedence on the nodes they share. After reset, a hit on way 8 together with an ordinary fill (victim 0) leaves way 12 as the next paired victim.
- R9: After reset, with all ways valid and no request, an ordinary-fill query reports victim 0 with action 1 (evict).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Fill request is committed this cycle (updates recency) |
| req_kind_i | input | 2 | 0 ordinary fill, 1 metadata-only fill, 2 return from delegation |
| way_valid_i | input | 20 | Valid bit of each metadata way |
| way_deleg_i | input | 20 | Delegated bit of each metadata way |
| hit_valid_i | input | 1 | A hit occurred on hit_way_i this cycle |
| hit_way_i | input | 5 | Way index of the hit |
| victim_way_o | output | 5 | Selected victim way |
| action_o | output | 2 | 0 place, 1 evict, 2 swap |

## Verification
A hit update and a fill update can reach the same recency tree in the same cycle. The bench provokes this right after reset by committing an ordinary fill, whose victim is way 0, in the same cycle as a hit on way 8. The two accesses disagree at the root node. It then reads the next paired victim: way 12 shows that the fill's update won, and way 4 would show that the hit's update won. The counter-driven group choice is checked across a whole counter period by querying without committing, so the trees stay fixed while only the draw changes.

// File: rtl/meta_way_victim_pkg.sv
package meta_way_victim_pkg;
  typedef enum logic [1:0] {
    KIND_NORMAL = 2'd0,
    KIND_DELEG  = 2'd1,
    KIND_RETURN = 2'd2
  } fill_kind_e;

  typedef enum logic [1:0] {
    ACT_PLACE = 2'd0,
    ACT_EVICT = 2'd1,
    ACT_SWAP  = 2'd2
  } fill_act_e;
endpackage

// File: rtl/lowest_free.sv
module lowest_free #(
  parameter int N  = 15,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/plru_tree.sv
module plru_tree #(
  parameter int NWAYS = 15,
  localparam int LVL    = $clog2(NWAYS),
  localparam int LEAVES = 1 << LVL,
  localparam int NODES  = LEAVES - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           upd_a_i,
  input  logic [LVL-1:0] way_a_i,
  input  logic           upd_b_i,   // applied after a
  input  logic [LVL-1:0] way_b_i,
  output logic [LVL-1:0] victim_o
);
  logic [NODES-1:0] bits_q, bits_d;

  function automatic logic [NODES-1:0] point_away(input logic [NODES-1:0] b,
                                                  input logic [LVL-1:0] w);
    int   node;
    logic dir;
    node = 1;
    for (int l = 0; l < LVL; l++) begin
      dir         = w[LVL-1-l];
      b[node-1]   = ~dir;
      node        = node * 2 + int'(dir);
    end
    return b;
  endfunction

  always_comb begin
    int node;
    int rbase;
    logic go_r;
    node = 1;
    for (int l = 0; l < LVL; l++) begin
      rbase = ((node * 2 + 1) << (LVL - 1 - l)) - LEAVES;
      go_r  = bits_q[node-1] && (rbase < NWAYS);
      node  = node * 2 + int'(go_r);
    end
    victim_o = LVL'(node - LEAVES);
  end

  always_comb begin
    bits_d = bits_q;
    if (upd_a_i) bits_d = point_away(bits_d, way_a_i);
    if (upd_b_i) bits_d = point_away(bits_d, way_b_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  bits_q <= '0;
    else if (upd_a_i || upd_b_i)  bits_q <= bits_d;
  end
endmodule

// File: rtl/meta_way_victim.sv
module meta_way_victim #(
  parameter int META_WAYS = 20,
  parameter int DATA_WAYS = 15,
  parameter int CNT_W     = 5,
  localparam int XTRA_WAYS = META_WAYS - DATA_WAYS,
  localparam int WAY_W     = $clog2(META_WAYS),
  localparam int PW        = $clog2(DATA_WAYS),
  localparam int XW        = $clog2(XTRA_WAYS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_kind_i,
  input  logic [META_WAYS-1:0] way_valid_i,
  input  logic [META_WAYS-1:0] way_deleg_i,
  input  logic                 hit_valid_i,
  input  logic [WAY_W-1:0]     hit_way_i,
  output logic [WAY_W-1:0]     victim_way_o,
  output logic [1:0]           action_o
);
  import meta_way_victim_pkg::*;

  logic [CNT_W-1:0] cyc_q;
  logic             pick_extra, use_x, grp_free;
  logic             p_found, x_found;
  logic [PW-1:0]    p_free, p_plru, p_cand;
  logic [XW-1:0]    x_free, x_plru, x_cand;
  logic             hit_in_x;
  logic [WAY_W-1:0] hit_x_rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + 1'b1;
  end

  // weighted draw: residue below DATA_WAYS picks the paired group
  assign pick_extra = (int'(cyc_q) % META_WAYS) >= DATA_WAYS;
  assign use_x      = (fill_kind_e'(req_kind_i) == KIND_DELEG) && pick_extra;

  lowest_free #(.N(DATA_WAYS)) u_p_free (
    .free_i (~way_valid_i[DATA_WAYS-1:0]),
    .found_o(p_found),
    .idx_o  (p_free)
  );

  lowest_free #(.N(XTRA_WAYS)) u_x_free (
    .free_i (~way_valid_i[META_WAYS-1:DATA_WAYS]),
    .found_o(x_found),
    .idx_o  (x_free)
  );

  assign p_cand    = p_found ? p_free : p_plru;
  assign x_cand    = x_found ? x_free : x_plru;
  assign hit_in_x  = hit_way_i >= WAY_W'(DATA_WAYS);
  assign hit_x_rel = hit_way_i - WAY_W'(DATA_WAYS);

  plru_tree #(.NWAYS(DATA_WAYS)) u_p_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_a_i (hit_valid_i && !hit_in_x),
    .way_a_i (hit_way_i[PW-1:0]),
    .upd_b_i (req_valid_i && !use_x),
    .way_b_i (p_cand),
    .victim_o(p_plru)
  );

  plru_tree #(.NWAYS(XTRA_WAYS)) u_x_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_a_i (hit_valid_i && hit_in_x),
    .way_a_i (hit_x_rel[XW-1:0]),
    .upd_b_i (req_valid_i && use_x),
    .way_b_i (x_cand),
    .victim_o(x_plru)
  );

  assign grp_free     = use_x ? x_found : p_found;
  assign victim_way_o = use_x ? WAY_W'(DATA_WAYS) + {{(WAY_W-XW){1'b0}}, x_cand}
                              : {{(WAY_W-PW){1'b0}}, p_cand};

  always_comb begin
    if (grp_free)
      action_o = ACT_PLACE;
    else if (fill_kind_e'(req_kind_i) == KIND_RETURN && way_deleg_i[victim_way_o])
      action_o = ACT_SWAP;
    else
      action_o = ACT_EVICT;
  end
endmodule

// File: rtl/meta_way_victim_chk.sv
module meta_way_victim_chk #(
  parameter int META_WAYS = 20,
  parameter int DATA_WAYS = 15,
  parameter int CNT_W     = 5,
  localparam int WAY_W    = $clog2(META_WAYS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           req_kind_i,
  input logic [META_WAYS-1:0] way_valid_i,
  input logic [META_WAYS-1:0] way_deleg_i,
  input logic [WAY_W-1:0]     victim_way_o,
  input logic [1:0]           action_o,
  input logic [CNT_W-1:0]     cyc_i
);
  a_r1_normal_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_kind_i == 2'd0 |-> victim_way_o < WAY_W'(DATA_WAYS));

  a_r3_return_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_kind_i == 2'd2 |-> victim_way_o < WAY_W'(DATA_WAYS));

  a_r3_swap_needs_deleg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 2'd2 |-> (req_kind_i == 2'd2 && way_deleg_i[victim_way_o]
                          && way_valid_i[victim_way_o]));

  a_r4_place_on_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 2'd0 |-> !way_valid_i[victim_way_o]);

  a_r4_evict_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 2'd1 |-> way_valid_i[victim_way_o]);

  a_r2_counter_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cyc_i == $past(cyc_i) + 1'b1);

  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_way_o < WAY_W'(META_WAYS));
endmodule

bind meta_way_victim meta_way_victim_chk #(
  .META_WAYS(META_WAYS), .DATA_WAYS(DATA_WAYS), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_kind_i  (req_kind_i),
  .way_valid_i (way_valid_i),
  .way_deleg_i (way_deleg_i),
  .victim_way_o(victim_way_o),
  .action_o    (action_o),
  .cyc_i       (cyc_q)
);

// File: tb/meta_way_victim_tb.sv
module meta_way_victim_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [19:0] way_valid = '1;
  logic [19:0] way_deleg = '0;
  logic        hit_valid = 1'b0;
  logic [4:0]  hit_way = '0;
  logic [4:0]  victim_way;
  logic [1:0]  action;
  logic [4:0]  bcnt;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  meta_way_victim u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_kind_i  (req_kind),
    .way_valid_i (way_valid),
    .way_deleg_i (way_deleg),
    .hit_valid_i (hit_valid),
    .hit_way_i   (hit_way),
    .victim_way_o(victim_way),
    .action_o    (action)
  );

  // cycles since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= bcnt + 5'd1;

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; hit_valid = 1'b0;
    way_valid = '1; way_deleg = '0; req_kind = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cnt(input int v);
    while (int'(bcnt) != v) @(negedge clk);
  endtask

  // drive at negedge, check before the next posedge, return at next negedge
  task automatic apply(input logic [1:0] kind, input logic rv, input logic hv,
                       input logic [4:0] hw, input int exp_way, input int exp_act,
                       input string req);
    req_kind = kind; req_valid = rv; hit_valid = hv; hit_way = hw;
    #1;
    n_chk++;
    if (int'(victim_way) != exp_way || int'(action) != exp_act) begin
      n_bad++;
      $display("FAIL %s: way=%0d act=%0d expected way=%0d act=%0d",
               req, victim_way, action, exp_way, exp_act);
    end
    @(negedge clk);
    req_valid = 1'b0; hit_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    apply(2'd0, 1'b0, 1'b0, 5'd0, 0, 1, "R9 reset state");
  endtask

  task automatic t_order();
    int seq[16] = '{0, 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7, 14};
    do_reset();
    for (int i = 0; i < 16; i++)
      apply(2'd0, 1'b1, 1'b0, 5'd0, seq[i], 1, i == 15 ? "R6 pad leaf" : "R5 R1 order");
  endtask

  task automatic t_free();
    do_reset();
    way_valid = '1; way_valid[7] = 1'b0; way_valid[3] = 1'b0;
    apply(2'd0, 1'b0, 1'b0, 5'd0, 3, 0, "R4 lowest free paired");
    way_valid = '1; way_valid[18] = 1'b0; way_valid[17] = 1'b0;
    wait_cnt(15);
    apply(2'd1, 1'b0, 1'b0, 5'd0, 17, 0, "R4 lowest free extra");
    way_valid = '1;
  endtask

  task automatic t_draw();
    do_reset();
    for (int i = 0; i < 32; i++) begin
      int c;
      c = int'(bcnt);
      apply(2'd1, 1'b0, 1'b0, 5'd0, ((c % 20) < 15) ? 0 : 15, 1, "R2 group draw");
    end
  endtask

  task automatic t_extra_order();
    do_reset();
    wait_cnt(15);
    apply(2'd1, 1'b1, 1'b0, 5'd0, 15, 1, "R5 extra first");
    apply(2'd1, 1'b0, 1'b0, 5'd0, 19, 1, "R5 extra second");
  endtask

  task automatic t_return();
    do_reset();
    way_deleg = '0; way_deleg[0] = 1'b1;
    apply(2'd2, 1'b0, 1'b0, 5'd0, 0, 2, "R3 swap delegated victim");
    way_deleg = '0; way_deleg[15] = 1'b1;
    apply(2'd2, 1'b0, 1'b0, 5'd0, 0, 1, "R3 evict undelegated victim");
    way_valid[0] = 1'b0;
    apply(2'd2, 1'b0, 1'b0, 5'd0, 0, 0, "R3 R4 return place");
    way_valid = '1; way_deleg = '0;
  endtask

  task automatic t_hit();
    do_reset();
    apply(2'd0, 1'b0, 1'b1, 5'd15, 0, 1, "R7 hit extra no paired move");
    apply(2'd0, 1'b0, 1'b0, 5'd0, 0, 1, "R7 paired unchanged");
    wait_cnt(16);
    apply(2'd1, 1'b0, 1'b0, 5'd0, 19, 1, "R7 extra moved by hit");
  endtask

  task automatic t_collide();
    do_reset();
    apply(2'd0, 1'b1, 1'b1, 5'd8, 0, 1, "R8 fill with hit");
    apply(2'd0, 1'b0, 1'b0, 5'd0, 12, 1, "R8 fill wins shared nodes");
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_order();
    t_free();
    t_draw();
    t_extra_order();
    t_return();
    t_hit();
    t_collide();
    finish_up();
  end
endmodule